// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block owns the program counter and the privilege mode of a small processor core. It decides what happens between one instruction and the next. When the core reports that an instruction has finished executing, the block advances the program counter. It then looks once at the pending interrupt request and at the software trap request. If either one is accepted, the block runs a fixed three-cycle entry sequence:

1. It saves the pair (program counter, mode) on an internal context stack.
2. It switches to privileged mode.
3. It loads the program counter from a handler table, indexed directly by the request number.

A return command pops the newest saved pair and restores both the mode and the program counter in one cycle.

The handler table is filled through a configuration write port, and it accepts writes only while reset is held. In a typical kernel, table slot 0 holds the process-switch handler, which a periodic timer interrupt triggers for preemption, and slot 1 holds the process-creation handler. A separate command lets privileged code drop to user mode at a chosen address.

Stack overflow, stack underflow and out-of-range request numbers set a sticky fault flag. In each of these cases the context and mode stay as they were, apart from the normal program counter advance.

Top module: `irqs_top`

## Requirements
- R1: While reset is held and right after it is released, `pc` equals RESET_PC (0), `priv` is 1 (privileged), `busy` is 0 and `fault` is 0.
- R2: An `instr_done` pulse with no accepted request increments `pc` by one at the next clock edge.
- R3: An `instr_done` with `irq_valid` and an in-range number n holds `busy` high for exactly three cycles. After that, `pc` equals handler table entry n and `priv` is 1.
- R4: During entry, `priv` becomes 1 at the end of the second busy cycle. `pc` keeps the incremented return value until the third busy cycle ends.
- R5: A trap (`trap_valid` with `instr_done`) saves the incremented `pc` and then enters exactly like interrupt `trap_num`. If a trap and an interrupt arrive together, the trap wins and the interrupt is not consumed by that check.
- R6: `rti` pops the newest saved pair and restores `priv` and `pc` from it, in last-in first-out order.
- R7: An entry attempted when the stack already holds STK_DEPTH (8) pairs sets `fault`, does not push, and leaves `priv` unchanged. `pc` keeps only its normal increment, and `busy` drops after one cycle.
- R8: `rti` with an empty stack sets `fault` and leaves `pc` and `priv` unchanged.
- R9: A request number at or above TBL_DEPTH (6) sets `fault`, starts no entry (`busy` stays 0), and `pc` only increments.
- R10: Handler table writes (`cfg_we`) take effect only while `rst` is 1. Writes made while `rst` is 0 are ignored.
- R11: While `busy` is 1, the inputs `instr_done`, `irq_valid`, `trap_valid`, `rti` and `enter_user` are ignored.
- R12: `fault` stays 1 once set, until reset.
- R13: `enter_user` in privileged mode sets `priv` to 0 and `pc` to `enter_pc`. In user mode it is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also the handler-table load window |
| cfg_we | input | 1 | Handler table write strobe |
| cfg_idx | input | NUM_W | Handler table slot to write |
| cfg_addr | input | PC_W | Handler address to store |
| instr_done | input | 1 | Current instruction finished executing (the check point) |
| irq_valid | input | 1 | Hardware interrupt pending |
| irq_num | input | NUM_W | Pending interrupt number |
| trap_valid | input | 1 | Finished instruction was a software trap |
| trap_num | input | NUM_W | Trap number |
| rti | input | 1 | Return-from-interrupt command |
| enter_user | input | 1 | Drop to user mode at `enter_pc` |
| enter_pc | input | PC_W | Start address for `enter_user` |
| pc | output | PC_W | Program counter |
| priv | output | 1 | 1 = privileged, 0 = user |
| busy | output | 1 | Entry sequence running; the fetch stage must stall |
| fault | output | 1 | Sticky fault flag |

## Verification
A corrupted saved pair only shows up when it is popped. The bench therefore follows every entry with a return and compares the restored `pc` and `priv` against the values the entry saved. A stack pointer that is off by one appears either as a wrong address on a later return or as a fault arriving one entry early or late. Deep nesting and an underflow attempt both expose it. Mis-sequencing inside the entry shows up within four cycles as a wrong `busy` length or a `priv` change at the wrong edge. A table that can be written outside reset shows up as a wrong handler address on the very next entry.

// File: rtl/irqs_pkg.sv
package irqs_pkg;

    localparam int PC_W = 16;

    typedef enum logic {
        MODE_USER = 1'b0,
        MODE_PRIV = 1'b1
    } mode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PUSH,
        ST_MODE,
        ST_LOAD
    } seq_state_e;

    typedef struct packed {
        logic [PC_W-1:0] pc;
        mode_e           mode;
    } ctx_t;

    function automatic logic [PC_W-1:0] pc_step(input logic [PC_W-1:0] cur);
        return cur + PC_W'(1);
    endfunction

endpackage

// File: rtl/irqs_ctx_stack.sv
module irqs_ctx_stack import irqs_pkg::*; #(
    parameter int DEPTH = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic push,
    input  logic pop,
    input  ctx_t push_ctx,
    output ctx_t top_ctx,
    output logic full,
    output logic empty
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    ctx_t             slots [DEPTH];
    logic [CNT_W-1:0] level;

    assign full    = (level == CNT_W'(DEPTH));
    assign empty   = (level == '0);
    assign top_ctx = empty ? '0 : slots[AW'(level - CNT_W'(1))];

    always_ff @(posedge clk) begin
        if (rst) begin
            level <= '0;
        end else if (push && !full) begin
            slots[AW'(level)] <= push_ctx;
            level             <= level + CNT_W'(1);
        end else if (pop && !empty) begin
            level <= level - CNT_W'(1);
        end
    end
endmodule

// File: rtl/irqs_vec_table.sv
module irqs_vec_table import irqs_pkg::*; #(
    parameter int NUM_W = 3,
    parameter int DEPTH = 6
) (
    input  logic             clk,
    input  logic             cfg_en,
    input  logic             we,
    input  logic [NUM_W-1:0] widx,
    input  logic [PC_W-1:0]  wdata,
    input  logic [NUM_W-1:0] ridx,
    output logic [PC_W-1:0]  rdata,
    output logic             in_range
);
    logic [PC_W-1:0] entry [DEPTH];

    generate
        if (DEPTH >= (1 << NUM_W)) begin : g_full
            assign in_range = 1'b1;
        end else begin : g_part
            assign in_range = (ridx < NUM_W'(DEPTH));
        end
    endgenerate

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_slot
            always_ff @(posedge clk) begin
                if (cfg_en && we && widx == NUM_W'(i)) entry[i] <= wdata;
            end
        end
    endgenerate

    always_comb begin
        rdata = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (ridx == NUM_W'(i)) rdata = entry[i];
        end
    end
endmodule

// File: rtl/irqs_seq_fsm.sv
module irqs_seq_fsm import irqs_pkg::*; #(
    parameter int              NUM_W    = 3,
    parameter logic [PC_W-1:0] RESET_PC = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             instr_done,
    input  logic             irq_valid,
    input  logic [NUM_W-1:0] irq_num,
    input  logic             trap_valid,
    input  logic [NUM_W-1:0] trap_num,
    input  logic             rti,
    input  logic             enter_user,
    input  logic [PC_W-1:0]  enter_pc,
    input  logic             stk_full,
    input  logic             stk_empty,
    input  ctx_t             stk_top,
    input  logic [PC_W-1:0]  vec_pc,
    input  logic             vec_ok,
    output logic [NUM_W-1:0] vec_idx,
    output logic             stk_push,
    output logic             stk_pop,
    output ctx_t             stk_wr,
    output logic [PC_W-1:0]  pc,
    output mode_e            mode,
    output logic             busy,
    output logic             fault
);
    seq_state_e       state;
    logic [NUM_W-1:0] num_q;
    logic             req;
    logic [NUM_W-1:0] req_num;

    // A trap is the finished instruction itself, so it takes precedence.
    assign req     = trap_valid | irq_valid;
    assign req_num = trap_valid ? trap_num : irq_num;
    assign vec_idx = (state == ST_IDLE) ? req_num : num_q;
    assign busy    = (state != ST_IDLE);

    assign stk_push = (state == ST_PUSH) && !stk_full;
    assign stk_pop  = (state == ST_IDLE) && rti && !stk_empty;
    assign stk_wr   = '{pc: pc, mode: mode};

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            pc    <= RESET_PC;
            mode  <= MODE_PRIV;
            num_q <= '0;
            fault <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (rti) begin
                        if (stk_empty) begin
                            fault <= 1'b1;
                        end else begin
                            mode <= stk_top.mode;
                            pc   <= stk_top.pc;
                        end
                    end else if (enter_user) begin
                        if (mode == MODE_PRIV) begin
                            mode <= MODE_USER;
                            pc   <= enter_pc;
                        end
                    end else if (instr_done) begin
                        pc <= pc_step(pc);
                        if (req) begin
                            if (vec_ok) begin
                                num_q <= req_num;
                                state <= ST_PUSH;
                            end else begin
                                fault <= 1'b1;
                            end
                        end
                    end
                end
                ST_PUSH: begin
                    if (stk_full) begin
                        fault <= 1'b1;
                        state <= ST_IDLE;
                    end else begin
                        state <= ST_MODE;
                    end
                end
                ST_MODE: begin
                    mode  <= MODE_PRIV;
                    state <= ST_LOAD;
                end
                ST_LOAD: begin
                    pc    <= vec_pc;
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/irqs_top.sv
module irqs_top import irqs_pkg::*; #(
    parameter int              NUM_W     = 3,
    parameter int              TBL_DEPTH = 6,
    parameter int              STK_DEPTH = 8,
    parameter logic [PC_W-1:0] RESET_PC  = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [NUM_W-1:0] cfg_idx,
    input  logic [PC_W-1:0]  cfg_addr,
    input  logic             instr_done,
    input  logic             irq_valid,
    input  logic [NUM_W-1:0] irq_num,
    input  logic             trap_valid,
    input  logic [NUM_W-1:0] trap_num,
    input  logic             rti,
    input  logic             enter_user,
    input  logic [PC_W-1:0]  enter_pc,
    output logic [PC_W-1:0]  pc,
    output logic             priv,
    output logic             busy,
    output logic             fault
);
    ctx_t             stk_top, stk_wr;
    logic             stk_full, stk_empty, stk_push, stk_pop;
    logic [NUM_W-1:0] vec_idx;
    logic [PC_W-1:0]  vec_pc;
    logic             vec_ok;
    mode_e            mode;

    assign priv = (mode == MODE_PRIV);

    irqs_ctx_stack #(.DEPTH(STK_DEPTH)) u_stack (
        .clk     (clk),
        .rst     (rst),
        .push    (stk_push),
        .pop     (stk_pop),
        .push_ctx(stk_wr),
        .top_ctx (stk_top),
        .full    (stk_full),
        .empty   (stk_empty)
    );

    irqs_vec_table #(.NUM_W(NUM_W), .DEPTH(TBL_DEPTH)) u_table (
        .clk     (clk),
        .cfg_en  (rst),
        .we      (cfg_we),
        .widx    (cfg_idx),
        .wdata   (cfg_addr),
        .ridx    (vec_idx),
        .rdata   (vec_pc),
        .in_range(vec_ok)
    );

    irqs_seq_fsm #(.NUM_W(NUM_W), .RESET_PC(RESET_PC)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .instr_done(instr_done),
        .irq_valid (irq_valid),
        .irq_num   (irq_num),
        .trap_valid(trap_valid),
        .trap_num  (trap_num),
        .rti       (rti),
        .enter_user(enter_user),
        .enter_pc  (enter_pc),
        .stk_full  (stk_full),
        .stk_empty (stk_empty),
        .stk_top   (stk_top),
        .vec_pc    (vec_pc),
        .vec_ok    (vec_ok),
        .vec_idx   (vec_idx),
        .stk_push  (stk_push),
        .stk_pop   (stk_pop),
        .stk_wr    (stk_wr),
        .pc        (pc),
        .mode      (mode),
        .busy      (busy),
        .fault     (fault)
    );
endmodule

// File: rtl/irqs_chk.sv
module irqs_chk import irqs_pkg::*; (
    input logic            clk,
    input logic            rst,
    input logic [PC_W-1:0] pc,
    input logic            priv,
    input logic            busy,
    input logic            fault,
    input logic            instr_done,
    input logic            irq_valid,
    input logic            trap_valid,
    input logic            rti,
    input logic            enter_user
);
    // R12: once raised, fault never clears without reset
    p_fault_sticky_r12: assert property (@(posedge clk) disable iff (rst)
        fault |=> fault);

    // R3: the entry sequence never lasts longer than three cycles
    p_busy_len_r3: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && $past(busy, 2)) |=> !busy);

    // R4: privileged mode is in force once the mode-change cycle completes
    p_priv_set_r4: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |=> priv);

    // R4 and R11: pc holds still between the push and the handler load
    p_pc_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (busy ##1 busy) |-> $stable(pc));

    // R2: a plain instruction completion advances pc by one
    p_seq_step_r2: assert property (@(posedge clk) disable iff (rst)
        (!busy && instr_done && !irq_valid && !trap_valid && !rti && !enter_user)
        |=> (pc == $past(pc) + PC_W'(1)));
endmodule

bind irqs_top irqs_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .pc        (pc),
    .priv      (priv),
    .busy      (busy),
    .fault     (fault),
    .instr_done(instr_done),
    .irq_valid (irq_valid),
    .trap_valid(trap_valid),
    .rti       (rti),
    .enter_user(enter_user)
);

// File: tb/tb_irqs_top.sv
module tb_irqs_top;
    import irqs_pkg::*;

    localparam int NUM_W = 3;
    localparam int TBL_DEPTH = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_we = 1'b0;
    logic [NUM_W-1:0] cfg_idx = '0;
    logic [PC_W-1:0] cfg_addr = '0;
    logic instr_done = 1'b0, irq_valid = 1'b0, trap_valid = 1'b0;
    logic [NUM_W-1:0] irq_num = '0, trap_num = '0;
    logic rti = 1'b0, enter_user = 1'b0;
    logic [PC_W-1:0] enter_pc = '0;
    logic [PC_W-1:0] pc;
    logic priv, busy, fault;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    irqs_top dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_addr(cfg_addr),
        .instr_done(instr_done), .irq_valid(irq_valid), .irq_num(irq_num),
        .trap_valid(trap_valid), .trap_num(trap_num), .rti(rti),
        .enter_user(enter_user), .enter_pc(enter_pc),
        .pc(pc), .priv(priv), .busy(busy), .fault(fault)
    );

    function automatic logic [PC_W-1:0] vec_of(input int n);
        return PC_W'(16'h100 + 16 * n);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_in();
        instr_done = 0; irq_valid = 0; trap_valid = 0; rti = 0; enter_user = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1;
        for (int i = 0; i < TBL_DEPTH; i++) begin
            cfg_we = 1; cfg_idx = NUM_W'(i); cfg_addr = vec_of(i);
            tick(1);
        end
        cfg_we = 0;
        rst = 0;
        tick(1);
    endtask

    task automatic irq_entry(input int n);
        instr_done = 1; irq_valid = 1; irq_num = NUM_W'(n);
        tick(1);
        clear_in();
        tick(3);
    endtask

    task automatic do_rti();
        rti = 1; tick(1); rti = 0;
    endtask

    task automatic t_reset_and_table();
        do_reset();
        chk("R1 pc", pc, 0); chk("R1 priv", priv, 1);
        chk("R1 busy", busy, 0); chk("R1 fault", fault, 0);
        cfg_we = 1; cfg_idx = 2; cfg_addr = 16'hDEAD;
        tick(1);
        cfg_we = 0;
        chk("R10 pc untouched by cfg write", pc, 0);
    endtask

    task automatic t_sequential();
        repeat (3) begin instr_done = 1; tick(1); end
        instr_done = 0;
        chk("R2 pc after three", pc, 3);
    endtask

    task automatic t_enter_user();
        enter_user = 1; enter_pc = 16'h40; tick(1); enter_user = 0;
        chk("R13 pc", pc, 16'h40); chk("R13 priv", priv, 0);
    endtask

    task automatic t_irq_entry();
        instr_done = 1; irq_valid = 1; irq_num = 2;
        tick(1);
        chk("R3 busy c1", busy, 1); chk("R4 priv c1", priv, 0); chk("R4 pc c1", pc, 16'h41);
        rti = 1; instr_done = 1; irq_valid = 1; irq_num = 3; enter_user = 1; enter_pc = 16'h77;
        tick(1);
        chk("R3 busy c2", busy, 1); chk("R4 priv c2", priv, 0);
        tick(1);
        clear_in();
        chk("R3 busy c3", busy, 1); chk("R4 priv c3", priv, 1); chk("R4 pc c3", pc, 16'h41);
        tick(1);
        chk("R3 busy done", busy, 0);
        chk("R10 R3 handler pc", pc, vec_of(2));
        chk("R11 no fault", fault, 0);
        tick(1);
        chk("R11 stays idle", pc, vec_of(2));
        do_rti();
        chk("R6 pc restored", pc, 16'h41); chk("R6 priv restored", priv, 0);
    endtask

    task automatic t_trap();
        instr_done = 1; trap_valid = 1; trap_num = 1; irq_valid = 1; irq_num = 3;
        tick(1);
        clear_in();
        tick(3);
        chk("R5 trap handler", pc, vec_of(1)); chk("R5 trap priv", priv, 1);
        do_rti();
        chk("R5 saved pc+1", pc, 16'h42); chk("R5 mode back", priv, 0);
        irq_entry(3);
        chk("R5 irq still pending", pc, vec_of(3));
        do_rti();
        chk("R6 second return", pc, 16'h43);
        enter_user = 1; enter_pc = 16'h77; tick(1); enter_user = 0;
        chk("R13 ignored in user pc", pc, 16'h43); chk("R13 ignored priv", priv, 0);
    endtask

    task automatic t_range();
        instr_done = 1; irq_valid = 1; irq_num = 7;
        tick(1);
        clear_in();
        chk("R9 fault", fault, 1); chk("R9 busy", busy, 0);
        chk("R9 pc", pc, 16'h44); chk("R9 priv", priv, 0);
        tick(3);
        chk("R12 still set", fault, 1); chk("R9 no late entry", pc, 16'h44);
        do_reset();
        chk("R12 cleared by reset", fault, 0);
    endtask

    task automatic t_underflow();
        do_rti();
        chk("R8 fault", fault, 1); chk("R8 pc", pc, 0); chk("R8 priv", priv, 1);
        do_reset();
    endtask

    task automatic t_overflow();
        for (int k = 0; k < 8; k++) irq_entry(0);
        chk("R7 before full pc", pc, vec_of(0)); chk("R7 before full fault", fault, 0);
        instr_done = 1; irq_valid = 1; irq_num = 0;
        tick(1);
        clear_in();
        chk("R7 busy push cycle", busy, 1);
        tick(1);
        chk("R7 busy drops", busy, 0); chk("R7 fault", fault, 1);
        chk("R7 pc increment only", pc, vec_of(0) + 1); chk("R7 priv", priv, 1);
        tick(2);
        chk("R7 no late load", pc, vec_of(0) + 1);
        for (int k = 0; k < 7; k++) do_rti();
        chk("R6 nested pc", pc, vec_of(0) + 1);
        do_rti();
        chk("R6 bottom pc", pc, 1); chk("R6 bottom priv", priv, 1);
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    endtask

    initial begin
        t_reset_and_table();
        t_sequential();
        t_enter_user();
        t_irq_entry();
        t_trap();
        t_range();
        t_underflow();
        t_overflow();
        finished = 1;
        summary();
        $finish;
    end

    initial begin
        #400000;
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual hung expected done");
            summary();
            $finish;
        end
    end
endmodule